// File: doc/BRIEF.md
# Any-Radix Carry-Lookahead Digit Adder

This block adds two numbers held as vectors of base-R digits. R is a parameter and does not need to be a power of two, so a decimal or ternary datapath can use it directly. Each digit sits in the smallest field that holds R-1. Digit 0 is the least significant and lives in the lowest bits of each packed vector. A global carry input enters at digit 0, and the carry out of the top digit comes out on its own pin.

Each digit position first adds its two input digits with no incoming carry. It compares that sum against R-1 to classify the position. A sum of exactly R-1 passes an incoming carry through. A sum of R or more produces a carry whatever comes in. These per-digit flags feed a parallel-prefix tree of pairwise span merges. The merge span doubles at each of log2(N) levels, so every inter-digit carry is resolved in logarithmic depth, with no ripple from digit to digit. Each result digit is then the provisional sum plus its resolved carry, reduced modulo R. The result digits and the carry out are captured in one output register, so a result appears one clock after its operands.

Top module: `rdx_cla_adder`

## Requirements
- R1: While `rst_n` is low the registered outputs are cleared: every result digit is 0 and `cout` is 0.
- R2: One clock edge after operands are applied, the value `sum_dig` read as a base-RADIX number, plus `cout` weighted RADIX^NDIG, equals `a_dig + b_dig + cin`, with each input also read in base RADIX. Digit i occupies bits [i*DW +: DW], and DW is the smallest width that holds RADIX-1.
- R3: Every output digit is below RADIX in every cycle.
- R4: `cout` is 1 exactly when the operand total including `cin` reaches RADIX^NDIG.
- R5: `cin` adds exactly one unit at digit 0. With `b_dig` zero and `cin` zero, `sum_dig` equals `a_dig` and `cout` is 0.
- R6: When every digit pair sums to exactly RADIX-1, the carry travels across all digits. With `cin`=1 the result is all-zero digits with `cout`=1. With `cin`=0 the result is all (RADIX-1) digits with `cout`=0.
- R7: A digit pair that sums to RADIX or more yields a carry into the next digit regardless of the carry arriving at that pair.
- R8: The result is correct for a radix that is not a power of two.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Active-low synchronous reset of the outputs |
| a_dig | input | NDIG*DW | First operand, packed base-RADIX digits, digit 0 lowest |
| b_dig | input | NDIG*DW | Second operand, same layout |
| cin | input | 1 | Carry into digit 0 |
| sum_dig | output | NDIG*DW | Registered result digits, each modulo RADIX |
| cout | output | 1 | Registered carry out of the top digit |

## Verification
On every cycle the assertions check the following:
- every output digit stays below the radix;
- the reset value is present on the first cycle after reset;
- adding zero with no carry returns the first operand unchanged;
- an all-propagate operand pair gives the expected all-zero or all-maximum result.

Arithmetic equality for general operands, and the exact threshold where the carry out switches, can only be shown by the bench. The bench compares every operand pair and carry of a small radix-3, four-digit configuration with integer sums it computes itself. That sweep covers isolated generates, long partial propagate chains and the full chain.

// File: rtl/rdx_cla_pkg.sv
package rdx_cla_pkg;
    // bits needed to hold values 0..maxval
    function automatic int bits_for(input int maxval);
        int w;
        w = 1;
        while ((1 << w) <= maxval) w++;
        return w;
    endfunction
endpackage

// File: rtl/rdx_digit_pg.sv
module rdx_digit_pg #(
    parameter int RADIX = 10,
    parameter int DW    = 4,
    parameter int SW    = 5
) (
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] b_i,
    output logic [SW-1:0] psum_o,
    output logic          prop_o,
    output logic          gen_o
);
    always_comb begin
        psum_o = SW'(a_i) + SW'(b_i);
        gen_o  = (psum_o >= SW'(RADIX));
        prop_o = (psum_o == SW'(RADIX - 1));
    end
endmodule

// File: rtl/rdx_prefix_tree.sv
module rdx_prefix_tree #(
    parameter int NDIG = 8,
    parameter int LVL  = 3
) (
    input  logic [NDIG-1:0] prop_i,
    input  logic [NDIG-1:0] gen_i,
    input  logic            cin_i,
    output logic [NDIG:0]   carry_o
);
    logic [NDIG-1:0] gl [LVL+1];
    logic [NDIG-1:0] pl [LVL+1];

    always_comb begin
        gl[0] = gen_i;
        pl[0] = prop_i;
        for (int lv = 0; lv < LVL; lv++) begin
            for (int i = 0; i < NDIG; i++) begin
                if (i >= (1 << lv)) begin
                    gl[lv+1][i] = gl[lv][i] | (pl[lv][i] & gl[lv][i-(1<<lv)]);
                    pl[lv+1][i] = pl[lv][i] & pl[lv][i-(1<<lv)];
                end else begin
                    gl[lv+1][i] = gl[lv][i];
                    pl[lv+1][i] = pl[lv][i];
                end
            end
        end
        carry_o[0] = cin_i;
        for (int i = 0; i < NDIG; i++) begin
            carry_o[i+1] = gl[LVL][i] | (pl[LVL][i] & cin_i);
        end
    end
endmodule

// File: rtl/rdx_digit_sum.sv
module rdx_digit_sum #(
    parameter int RADIX = 10,
    parameter int DW    = 4,
    parameter int SW    = 5
) (
    input  logic [SW-1:0] psum_i,
    input  logic          cin_i,
    output logic [DW-1:0] dig_o
);
    logic [SW-1:0] tot;
    logic [SW-1:0] red;
    always_comb begin
        tot = psum_i + SW'(cin_i);
        red = (tot >= SW'(RADIX)) ? (tot - SW'(RADIX)) : tot;
        dig_o = red[DW-1:0];
    end
endmodule

// File: rtl/rdx_cla_adder.sv
module rdx_cla_adder #(
    parameter int RADIX = 10,
    parameter int NDIG  = 8,
    parameter int DW    = rdx_cla_pkg::bits_for(RADIX - 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NDIG*DW-1:0] a_dig,
    input  logic [NDIG*DW-1:0] b_dig,
    input  logic              cin,
    output logic [NDIG*DW-1:0] sum_dig,
    output logic              cout
);
    localparam int SW  = rdx_cla_pkg::bits_for(2*RADIX - 1);
    localparam int LVL = (NDIG > 1) ? $clog2(NDIG) : 0;

    logic [SW-1:0]      psum [NDIG];
    logic [NDIG-1:0]    prop;
    logic [NDIG-1:0]    gen;
    logic [NDIG:0]      carry;
    logic [NDIG*DW-1:0] sum_nx;

    for (genvar d = 0; d < NDIG; d++) begin : g_dig
        rdx_digit_pg #(.RADIX(RADIX), .DW(DW), .SW(SW)) u_pg (
            .a_i    (a_dig[d*DW +: DW]),
            .b_i    (b_dig[d*DW +: DW]),
            .psum_o (psum[d]),
            .prop_o (prop[d]),
            .gen_o  (gen[d])
        );
        rdx_digit_sum #(.RADIX(RADIX), .DW(DW), .SW(SW)) u_sum (
            .psum_i (psum[d]),
            .cin_i  (carry[d]),
            .dig_o  (sum_nx[d*DW +: DW])
        );
    end

    rdx_prefix_tree #(.NDIG(NDIG), .LVL(LVL)) u_tree (
        .prop_i  (prop),
        .gen_i   (gen),
        .cin_i   (cin),
        .carry_o (carry)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_dig <= '0;
            cout    <= 1'b0;
        end else begin
            sum_dig <= sum_nx;
            cout    <= carry[NDIG];
        end
    end
endmodule

// File: rtl/rdx_cla_adder_chk.sv
module rdx_cla_adder_chk #(
    parameter int RADIX = 10,
    parameter int NDIG  = 8,
    parameter int DW    = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NDIG*DW-1:0] a_dig,
    input logic [NDIG*DW-1:0] b_dig,
    input logic               cin,
    input logic [NDIG*DW-1:0] sum_dig,
    input logic               cout
);
    logic all_pass;
    logic [NDIG*DW-1:0] all_max;
    always_comb begin
        all_pass = 1'b1;
        for (int i = 0; i < NDIG; i++) begin
            if (int'(a_dig[i*DW +: DW]) + int'(b_dig[i*DW +: DW]) != RADIX - 1)
                all_pass = 1'b0;
            all_max[i*DW +: DW] = DW'(RADIX - 1);
        end
    end

    for (genvar d = 0; d < NDIG; d++) begin : g_rng
        a_r3_digit_range: assert property (@(posedge clk) disable iff (!rst_n)
            int'(sum_dig[d*DW +: DW]) < RADIX);
    end

    a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (sum_dig == '0 && !cout));

    a_r5_add_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(b_dig) == '0 && !$past(cin))
        |-> (sum_dig == $past(a_dig) && !cout));

    a_r6_chain_carry: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(all_pass) && $past(cin))
        |-> (sum_dig == '0 && cout));

    a_r6_chain_still: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(all_pass) && !$past(cin))
        |-> (sum_dig == all_max && !cout));
endmodule

bind rdx_cla_adder rdx_cla_adder_chk #(.RADIX(RADIX), .NDIG(NDIG), .DW(DW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .a_dig   (a_dig),
    .b_dig   (b_dig),
    .cin     (cin),
    .sum_dig (sum_dig),
    .cout    (cout)
);

// File: tb/rdx_cla_adder_bench.sv
module rdx_cla_adder_bench;
    localparam int RADIX = 3;
    localparam int NDIG  = 4;
    localparam int DW    = 2;
    localparam int SPAN  = 81;   // RADIX**NDIG

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NDIG*DW-1:0] a_dig = '0;
    logic [NDIG*DW-1:0] b_dig = '0;
    logic cin = 1'b0;
    logic [NDIG*DW-1:0] sum_dig;
    logic cout;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    rdx_cla_adder #(.RADIX(RADIX), .NDIG(NDIG)) u_rdx_cla_adder (
        .clk(clk), .rst_n(rst_n), .a_dig(a_dig), .b_dig(b_dig),
        .cin(cin), .sum_dig(sum_dig), .cout(cout)
    );

    function automatic logic [NDIG*DW-1:0] to_dig(input int v);
        logic [NDIG*DW-1:0] r;
        int t;
        t = v;
        for (int i = 0; i < NDIG; i++) begin
            r[i*DW +: DW] = DW'(t % RADIX);
            t = t / RADIX;
        end
        return r;
    endfunction

    function automatic int from_dig(input logic [NDIG*DW-1:0] d);
        int v;
        v = 0;
        for (int i = NDIG-1; i >= 0; i--) v = v * RADIX + int'(d[i*DW +: DW]);
        return v;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", int'(sum_dig), 0);
        check("R1", int'(cout), 0);
        rst_n = 1'b1;
        for (int ia = 0; ia < SPAN; ia++) begin
            for (int ib = 0; ib < SPAN; ib++) begin
                for (int c = 0; c < 2; c++) begin
                    int tot;
                    int gens;
                    bit chain;
                    bit bad_dig;
                    a_dig = to_dig(ia);
                    b_dig = to_dig(ib);
                    cin   = c[0];
                    @(negedge clk);
                    tot = ia + ib + c;
                    // R2 / R8: integer value of result in radix 3
                    check("R2/R8 value", from_dig(sum_dig) + (cout ? SPAN : 0), tot);
                    // R4: carry out threshold
                    check("R4 cout", int'(cout), (tot >= SPAN) ? 1 : 0);
                    // R3: digits in range
                    bad_dig = 1'b0;
                    for (int i = 0; i < NDIG; i++)
                        if (int'(sum_dig[i*DW +: DW]) >= RADIX) bad_dig = 1'b1;
                    check("R3 digit range", int'(bad_dig), 0);
                    // R5: adding zero without carry is identity
                    if (ib == 0 && c == 0) check("R5 identity", int'(sum_dig), int'(a_dig));
                    // R6: full propagate chain
                    chain = 1'b1;
                    for (int i = 0; i < NDIG; i++)
                        if (int'(a_dig[i*DW +: DW]) + int'(b_dig[i*DW +: DW]) != RADIX-1) chain = 1'b0;
                    if (chain) begin
                        check("R6 chain digits", int'(sum_dig), c ? 0 : int'(to_dig(SPAN-1)));
                        check("R6 chain cout", int'(cout), c);
                    end
                    // R7: top digit generates -> carry out regardless of lower carry
                    gens = int'(a_dig[(NDIG-1)*DW +: DW]) + int'(b_dig[(NDIG-1)*DW +: DW]);
                    if (gens >= RADIX) check("R7 generate", int'(cout), 1);
                end
            end
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule